// File: doc/BRIEF.md
# Colored Capability Access Gate

This block sits between a bus master and memory. Each request carries a capability: lower bound, exclusive upper bound, a three-bit permission set and an address-space color. The block first applies the usual capability rules (the access must lie inside the bounds and hold the right permissions). It then applies the color rules. The color of the requesting address space may not differ from the capability's color. A store that writes a valid capability may not land in memory owned by another color. A request that passes every check is forwarded. A request that fails is answered with an error response instead, and is never forwarded.

The address-space color of a request comes from one of three places, picked by a mode register: the capability's own color bits, a side-band input that travels with the request, or a register holding the color of the interconnect port. A table of eight programmable regions gives each address range its owning color.

A separate derive port checks operations that build one capability from another. Such an operation is flagged when its two source capabilities carry different colors, or when the result's color differs from its parent's. Every request and every derive check gets its answer one clock after it is presented.

Top module: `cap_color_gate`

## Requirements
- R1: After reset, no forward, error or derive-fault output is active, the status record is clear (valid 0, address 0, code 0), every region is disabled and the color-source mode is 0.
- R2: A request presented with `req_valid` high gets exactly one of `fwd_valid` or `err_valid` on the following cycle. A cycle with no request produces neither.
- R3: A request is rejected with code 1 (bounds) when `req_addr` is below `cap_base`, or when `req_addr + req_len` exceeds `cap_top`. The upper bound is exclusive.
- R4: Permission bit 0 grants reads, bit 1 grants writes, and bit 2 grants storing a valid capability. A read needs bit 0, an untagged write needs bit 1, and a tagged write needs both bit 1 and bit 2. A request that lacks them is rejected with code 2.
- R5: The effective color depends on the mode register. Mode 0 takes `cap_color`, mode 1 takes `sb_color`, and mode 2 takes the programmed port color. A write of mode 3 is ignored and leaves the previous mode in force.
- R6: In modes 1 and 2, a request whose `cap_color` differs from the effective color is rejected with code 3 (color mixing).
- R7: A tagged write whose address falls in an enabled region owned by a color other than the effective color is rejected with code 4. A region covers the range from its low address to its high address, both ends included. When regions overlap, the lowest index wins.
- R8: A tagged write whose address matches no enabled region is rejected with code 5. Reads, tagged reads and untagged writes are not affected by the region table.
- R9: When several faults apply, the reported code is the first in the order bounds, permission, color mixing, region.
- R10: A forwarded request carries the request's address, its write and tag flags, and the effective color on `fwd_color`.
- R11: Each rejection records the faulting address and its code in the status outputs and sets `stat_valid`, which then stays set. A forwarded request leaves the status unchanged.
- R12: One cycle after a derive check is presented with `drv_valid`, `drv_fault` is high exactly when the two source colors differ or the result color differs from the first (parent) color. It is low when `drv_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode_we | input | 1 | Write strobe for the color-source mode |
| cfg_mode | input | 2 | New mode (0 capability, 1 side-band, 2 port; 3 ignored) |
| cfg_pcol_we | input | 1 | Write strobe for the port color |
| cfg_pcol | input | CW | New port color |
| rgn_we | input | 1 | Write strobe for one region entry |
| rgn_idx | input | IW | Region entry index |
| rgn_en | input | 1 | Entry enable |
| rgn_lo | input | AW | First address of the region |
| rgn_hi | input | AW | Last address of the region (inclusive) |
| rgn_color | input | CW | Owning color of the region |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_tag | input | 1 | Data is a valid capability |
| req_addr | input | AW | Request start address |
| req_len | input | LW | Request length in bytes |
| cap_base | input | AW | Capability lower bound |
| cap_top | input | AW | Capability upper bound (exclusive) |
| cap_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 capability store |
| cap_color | input | CW | Color bits held in the capability |
| sb_color | input | CW | Side-band color for the request |
| fwd_valid | output | 1 | Request forwarded to memory |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_tag | output | 1 | Forwarded tag flag |
| fwd_addr | output | AW | Forwarded address |
| fwd_color | output | CW | Effective color of the forwarded request |
| err_valid | output | 1 | Error response |
| err_code | output | 3 | Fault code (1 bounds, 2 permission, 3 mixing, 4 foreign region, 5 unmapped) |
| stat_valid | output | 1 | A fault has been recorded since reset |
| stat_addr | output | AW | Address of the latest fault |
| stat_code | output | 3 | Code of the latest fault |
| drv_valid | input | 1 | Derive check present |
| drv_a_color | input | CW | Parent capability color |
| drv_b_color | input | CW | Second source capability color |
| drv_res_color | input | CW | Result capability color |
| drv_fault | output | 1 | Derive check failed |

## Verification
The main sweep walks addresses from below the lower bound to past the upper bound, across every permission set, every access kind (read, write, tagged write, tagged read) and every capability color. It does this over a region map with overlapping, disabled and unmapped ranges. This separates bounds faults from permission faults and region faults, and it shows which code wins when several apply. A second sweep runs modes 1 and 2 over every combination of capability, side-band and port color. It tells a mixing fault apart from a region-ownership fault, and it shows that the forwarded color follows the selected source. A final sweep covers every color triple on the derive port.

// File: rtl/cap_color_gate.sv
module cap_color_gate #(
  parameter int AW   = 16,
  parameter int CW   = 2,
  parameter int NREG = 8,
  parameter int LW   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_pcol_we,
  input  logic [CW-1:0] cfg_pcol,
  input  logic          rgn_we,
  input  logic [IW-1:0] rgn_idx,
  input  logic          rgn_en,
  input  logic [AW-1:0] rgn_lo,
  input  logic [AW-1:0] rgn_hi,
  input  logic [CW-1:0] rgn_color,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_tag,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [AW-1:0] cap_base,
  input  logic [AW-1:0] cap_top,
  input  logic [2:0]    cap_perm,
  input  logic [CW-1:0] cap_color,
  input  logic [CW-1:0] sb_color,
  output logic          fwd_valid,
  output logic          fwd_write,
  output logic          fwd_tag,
  output logic [AW-1:0] fwd_addr,
  output logic [CW-1:0] fwd_color,
  output logic          err_valid,
  output logic [2:0]    err_code,
  output logic          stat_valid,
  output logic [AW-1:0] stat_addr,
  output logic [2:0]    stat_code,
  input  logic          drv_valid,
  input  logic [CW-1:0] drv_a_color,
  input  logic [CW-1:0] drv_b_color,
  input  logic [CW-1:0] drv_res_color,
  output logic          drv_fault
);

  logic [1:0]    mode_q;
  logic [CW-1:0] pcol_q;
  logic          r_en  [NREG];
  logic [AW-1:0] r_lo  [NREG];
  logic [AW-1:0] r_hi  [NREG];
  logic [CW-1:0] r_col [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      pcol_q <= '0;
    end else begin
      if (cfg_mode_we && cfg_mode != 2'd3) mode_q <= cfg_mode;
      if (cfg_pcol_we) pcol_q <= cfg_pcol;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_en[g]  <= 1'b0;
        r_lo[g]  <= '0;
        r_hi[g]  <= '0;
        r_col[g] <= '0;
      end else if (rgn_we && rgn_idx == IW'(g)) begin
        r_en[g]  <= rgn_en;
        r_lo[g]  <= rgn_lo;
        r_hi[g]  <= rgn_hi;
        r_col[g] <= rgn_color;
      end
    end
  end

  logic [CW-1:0] eff_col;
  assign eff_col = (mode_q == 2'd1) ? sb_color :
                   (mode_q == 2'd2) ? pcol_q   : cap_color;

  logic          hit;
  logic [CW-1:0] hit_col;
  always_comb begin
    hit     = 1'b0;
    hit_col = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (r_en[i] && req_addr >= r_lo[i] && req_addr <= r_hi[i]) begin
        hit     = 1'b1;
        hit_col = r_col[i];
      end
    end
  end

  logic [AW:0] end_addr;
  assign end_addr = {1'b0, req_addr} + (AW+1)'(req_len);

  logic cap_store, bnd_bad, perm_bad, mix_bad;
  assign cap_store = req_write && req_tag;
  assign bnd_bad   = (req_addr < cap_base) || (end_addr > {1'b0, cap_top});
  assign perm_bad  = req_write ? (!cap_perm[1] || (req_tag && !cap_perm[2])) : !cap_perm[0];
  assign mix_bad   = (mode_q != 2'd0) && (cap_color != eff_col);

  logic [2:0] code;
  always_comb begin
    if (bnd_bad)                             code = 3'd1;
    else if (perm_bad)                       code = 3'd2;
    else if (mix_bad)                        code = 3'd3;
    else if (cap_store && !hit)              code = 3'd5;
    else if (cap_store && hit_col != eff_col) code = 3'd4;
    else                                     code = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_write  <= 1'b0;
      fwd_tag    <= 1'b0;
      fwd_addr   <= '0;
      fwd_color  <= '0;
      err_valid  <= 1'b0;
      err_code   <= 3'd0;
      stat_valid <= 1'b0;
      stat_addr  <= '0;
      stat_code  <= 3'd0;
      drv_fault  <= 1'b0;
    end else begin
      fwd_valid <= req_valid && code == 3'd0;
      err_valid <= req_valid && code != 3'd0;
      err_code  <= req_valid ? code : 3'd0;
      if (req_valid && code == 3'd0) begin
        fwd_write <= req_write;
        fwd_tag   <= req_tag;
        fwd_addr  <= req_addr;
        fwd_color <= eff_col;
      end
      if (req_valid && code != 3'd0) begin
        stat_valid <= 1'b1;
        stat_addr  <= req_addr;
        stat_code  <= code;
      end
      drv_fault <= drv_valid &&
                   (drv_a_color != drv_b_color || drv_res_color != drv_a_color);
    end
  end

endmodule

module cap_color_gate_chk #(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_tag,
  input logic [AW-1:0] req_addr,
  input logic [AW-1:0] cap_base,
  input logic [2:0]    cap_perm,
  input logic          fwd_valid,
  input logic          fwd_write,
  input logic          fwd_tag,
  input logic          err_valid,
  input logic [2:0]    err_code,
  input logic          stat_valid,
  input logic [AW-1:0] stat_addr,
  input logic [2:0]    stat_code,
  input logic          drv_valid,
  input logic [CW-1:0] drv_a_color,
  input logic [CW-1:0] drv_b_color,
  input logic          drv_fault
);

  assert_one_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (fwd_valid ^ err_valid));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(fwd_valid || err_valid));

  assert_reject_not_forwarded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && err_valid));

  assert_fwd_in_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(req_addr >= cap_base));

  assert_tag_store_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_write && fwd_tag) |-> $past(cap_perm[1] && cap_perm[2]));

  assert_status_follows_error_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (stat_valid && stat_code == err_code && stat_addr == $past(req_addr)));

  assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> stat_valid);

  assert_derive_mix_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && drv_a_color != drv_b_color) |=> drv_fault);

  assert_derive_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_valid |=> !drv_fault);

  assert_fwd_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_write == $past(req_write) && fwd_tag == $past(req_tag)));

endmodule

bind cap_color_gate cap_color_gate_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_write(req_write), .req_tag(req_tag),
  .req_addr(req_addr), .cap_base(cap_base), .cap_perm(cap_perm),
  .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_tag(fwd_tag),
  .err_valid(err_valid), .err_code(err_code),
  .stat_valid(stat_valid), .stat_addr(stat_addr), .stat_code(stat_code),
  .drv_valid(drv_valid), .drv_a_color(drv_a_color), .drv_b_color(drv_b_color),
  .drv_fault(drv_fault)
);

// File: tb/cap_color_gate_bench.sv
module cap_color_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 2;
  localparam int NREG = 8;
  localparam int LW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          cfg_mode_we = 0, cfg_pcol_we = 0, rgn_we = 0, rgn_en = 0;
  logic [1:0]    cfg_mode = 0;
  logic [CW-1:0] cfg_pcol = 0, rgn_color = 0, cap_color = 0, sb_color = 0;
  logic [IW-1:0] rgn_idx = 0;
  logic [AW-1:0] rgn_lo = 0, rgn_hi = 0, req_addr = 0, cap_base = 0, cap_top = 0;
  logic          req_valid = 0, req_write = 0, req_tag = 0;
  logic [LW-1:0] req_len = 0;
  logic [2:0]    cap_perm = 0;
  logic          drv_valid = 0;
  logic [CW-1:0] drv_a_color = 0, drv_b_color = 0, drv_res_color = 0;
  logic          fwd_valid, fwd_write, fwd_tag, err_valid, stat_valid, drv_fault;
  logic [AW-1:0] fwd_addr, stat_addr;
  logic [CW-1:0] fwd_color;
  logic [2:0]    err_code, stat_code;

  cap_color_gate #(.AW(AW), .CW(CW), .NREG(NREG), .LW(LW)) u_cap_color_gate (
    .clk(clk), .rst_n(rst_n),
    .cfg_mode_we(cfg_mode_we), .cfg_mode(cfg_mode),
    .cfg_pcol_we(cfg_pcol_we), .cfg_pcol(cfg_pcol),
    .rgn_we(rgn_we), .rgn_idx(rgn_idx), .rgn_en(rgn_en),
    .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_color(rgn_color),
    .req_valid(req_valid), .req_write(req_write), .req_tag(req_tag),
    .req_addr(req_addr), .req_len(req_len),
    .cap_base(cap_base), .cap_top(cap_top), .cap_perm(cap_perm),
    .cap_color(cap_color), .sb_color(sb_color),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_tag(fwd_tag),
    .fwd_addr(fwd_addr), .fwd_color(fwd_color),
    .err_valid(err_valid), .err_code(err_code),
    .stat_valid(stat_valid), .stat_addr(stat_addr), .stat_code(stat_code),
    .drv_valid(drv_valid), .drv_a_color(drv_a_color), .drv_b_color(drv_b_color),
    .drv_res_color(drv_res_color), .drv_fault(drv_fault)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          m_en  [NREG];
  int            m_lo  [NREG];
  int            m_hi  [NREG];
  int            m_col [NREG];
  int            m_mode = 0;
  int            m_pcol = 0;
  logic          m_sv = 0;
  int            m_saddr = 0;
  int            m_scode = 0;

  function automatic string req_tag_of(int code);
    case (code)
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic int eff_of(int cc, int sb);
    if (m_mode == 1) return sb;
    if (m_mode == 2) return m_pcol;
    return cc;
  endfunction

  // Priority per R9: bounds, permission, mixing, region.
  function automatic int exp_code(bit w, bit t, int a, int l, int b, int tp, int p, int cc, int sb);
    int eff = eff_of(cc, sb);
    int hc = -1;
    if (a < b || a + l > tp) return 1;
    if (w ? (!p[1] || (t && !p[2])) : !p[0]) return 2;
    if (m_mode != 0 && cc != eff) return 3;
    if (w && t) begin
      for (int i = 0; i < NREG; i++)
        if (hc < 0 && m_en[i] && a >= m_lo[i] && a <= m_hi[i]) hc = m_col[i];
      if (hc < 0) return 5;
      if (hc != eff) return 4;
    end
    return 0;
  endfunction

  task automatic fail(string rq, string what, int act, int expv);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
  endtask

  task automatic prog_region(int idx, bit en, int lo, int hi, int col);
    rgn_we = 1; rgn_idx = IW'(idx); rgn_en = en;
    rgn_lo = AW'(lo); rgn_hi = AW'(hi); rgn_color = CW'(col);
    @(negedge clk);
    rgn_we = 0;
    m_en[idx] = en; m_lo[idx] = lo; m_hi[idx] = hi; m_col[idx] = col;
  endtask

  task automatic set_mode(int md);
    cfg_mode_we = 1; cfg_mode = 2'(md);
    @(negedge clk);
    cfg_mode_we = 0;
    if (md != 3) m_mode = md;
  endtask

  task automatic set_pcol(int c);
    cfg_pcol_we = 1; cfg_pcol = CW'(c);
    @(negedge clk);
    cfg_pcol_we = 0;
    m_pcol = c;
  endtask

  task automatic xact(string rq_hint, bit w, bit t, int a, int l, int b, int tp, int p, int cc, int sb);
    int code = exp_code(w, t, a, l, b, tp, p, cc, sb);
    int ecol = eff_of(cc, sb);
    string rq = (code == 0 && rq_hint != "") ? rq_hint : req_tag_of(code);
    req_valid = 1; req_write = w; req_tag = t; req_addr = AW'(a); req_len = LW'(l);
    cap_base = AW'(b); cap_top = AW'(tp); cap_perm = 3'(p);
    cap_color = CW'(cc); sb_color = CW'(sb);
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (code == 0) begin
      if (!fwd_valid || err_valid) fail(rq, "fwd/err", {fwd_valid, err_valid}, 2);
      else if (fwd_addr != AW'(a)) fail(rq, "fwd_addr", fwd_addr, a);
      else if (fwd_write != w || fwd_tag != t) fail(rq, "fwd_kind", {fwd_write, fwd_tag}, {w, t});
      else if (fwd_color != CW'(ecol)) fail(rq, "fwd_color", fwd_color, ecol);
      else if (stat_valid != m_sv || stat_addr != AW'(m_saddr) || stat_code != 3'(m_scode))
        fail("R11", "status changed on forward", stat_code, m_scode);
    end else begin
      m_sv = 1; m_saddr = a; m_scode = code;
      if (fwd_valid || !err_valid) fail(rq, "fwd/err", {fwd_valid, err_valid}, 1);
      else if (err_code != 3'(code)) fail(rq, "err_code", err_code, code);
      else if (!stat_valid || stat_addr != AW'(a) || stat_code != 3'(code))
        fail("R11", "status record", {stat_addr, stat_code}, {a[7:0], code[2:0]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin m_en[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_col[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    checks++;
    if (fwd_valid || err_valid || drv_fault || stat_valid || stat_addr != 0 || stat_code != 0)
      fail("R1", "reset outputs", {fwd_valid, err_valid, drv_fault, stat_valid}, 0);
    // R1: all regions disabled -> tagged store in mode 0 is unmapped
    xact("R1", 1, 1, 8'h20, 4, 0, 255, 7, 0, 0);
    // R2: idle cycle produces nothing
    @(negedge clk);
    checks++;
    if (fwd_valid || err_valid) fail("R2", "idle response", {fwd_valid, err_valid}, 0);

    for (int i = 0; i < 7; i++) prog_region(i, 1, i*16, i*16 + 15, i % 4);
    prog_region(7, 1, 8'h68, 8'h7F, 1);
    prog_region(5, 0, 8'h50, 8'h5F, 1);

    // Main sweep, mode 0: R3 R4 R7 R8 R9 R10
    for (int a = 0; a < 256; a += 3)
      for (int p = 0; p < 8; p++)
        for (int k = 0; k < 4; k++)
          for (int cc = 0; cc < 4; cc++)
            xact("R10", k[0] ^ k[1], k[1], a, 4, 8'h10, 8'hD0, p, cc, 3 - cc);

    // Exclusive upper bound edge, R3
    xact("R3", 0, 0, 8'hCC, 4, 8'h10, 8'hD0, 7, 0, 0);
    xact("R3", 0, 0, 8'hCD, 4, 8'h10, 8'hD0, 7, 0, 0);
    // Inclusive region high edge, R7: 0x1F in region 1 (color 1), 0x20 in region 2 (color 2)
    xact("R7", 1, 1, 8'h1F, 1, 0, 255, 7, 1, 0);
    xact("R7", 1, 1, 8'h20, 1, 0, 255, 7, 1, 0);

    // Modes 1 and 2: R5 R6
    for (int md = 1; md < 3; md++) begin
      set_mode(md);
      for (int pc = 0; pc < 4; pc++) begin
        set_pcol(pc);
        for (int cc = 0; cc < 4; cc++)
          for (int sb = 0; sb < 4; sb++)
            for (int k = 0; k < 4; k++)
              for (int j = 0; j < 3; j++)
                xact("R5", k[0] ^ k[1], k[1], (j == 0) ? 8'h40 : (j == 1) ? 8'h75 : 8'h90,
                     4, 0, 255, 7, cc, sb);
      end
    end

    // R5: mode 3 write ignored; mode stays 2, port color 1
    set_pcol(1);
    set_mode(3);
    xact("R5", 0, 0, 8'h30, 4, 0, 255, 7, 1, 3);
    set_mode(1);
    xact("R5", 0, 0, 8'h30, 4, 0, 255, 7, 2, 2);
    set_mode(0);

    // R12: derive port
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 4; r++) begin
          drv_valid = 1; drv_a_color = CW'(a); drv_b_color = CW'(b); drv_res_color = CW'(r);
          @(negedge clk);
          drv_valid = 0;
          checks++;
          if (drv_fault != (a != b || r != a)) fail("R12", "drv_fault", drv_fault, (a != b || r != a));
          @(negedge clk);
          checks++;
          if (drv_fault) fail("R12", "drv_fault idle", drv_fault, 0);
        end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule